// File: doc/BRIEF.md
# Multi-Lane Serial Flash Frame Sequencer

This block is an SPI master engine that runs one transaction, called a frame, at a time. A frame is described by a byte count, a count of leading transmit-only bytes, a number of idle SCLK periods, a lane mode, a lane width and a clock divider. All of these are presented on configuration inputs and captured by a one-cycle start strobe while the engine is ready. The engine then drives the chip select, the serial clock and up to four data lanes with per-lane output enables. It pulls outgoing bytes from a simple byte source and returns each byte it receives in the data phase as a one-cycle strobe.

The leading bytes form the command phase, made of an opcode byte and any address bytes. They are shifted out and whatever they receive is dropped. An optional gap of idle clocks follows. The data phase then shifts the remaining bytes and returns what the lanes carry. The lane mode chooses which of these phases use a single line and which use two or four lines. A multi-lane data phase is always a receive phase, and the engine releases the lanes during it.

Top module: `spi_frame_seq`

## Requirements
- R1: The frame length is `{cfg_len_hi, cfg_len_lo}` bytes. `cs_n` stays low from the start edge until one SCLK period after the last bit period, so it is low for exactly (bit periods + idle periods + 1) x SCLK period system clocks.
- R2: The SCLK period is 2*N system clocks, where N is `cfg_div` captured at start. A value of 0 behaves as 1.
- R3: Bytes with index below `cfg_cmd_len` are only transmitted and produce no `rx_valid`. When the command count is equal to or greater than the total, the frame returns no byte. When the command count is zero, every byte is returned.
- R4: Received bits are sampled at the rising SCLK edge and assembled MSB first. A single-lane byte takes DQ1. A dual-lane beat takes {DQ1,DQ0}. A quad-lane beat takes {DQ3,DQ2,DQ1,DQ0}.
- R5: Lane mode, with byte index k and command count C: 00 puts every byte on one lane (out on DQ0, in on DQ1). 01 uses one lane for k<C and multiple lanes after that. 10 uses one lane for k=0 only. 11 uses multiple lanes for all bytes. With `cfg_quad`=0 the multiple lanes are DQ1:DQ0 (out MSB on DQ1). With `cfg_quad`=1 they are DQ3:DQ0 (out MSB on DQ3).
- R6: When 0 < C < total, `cfg_idle` SCLK periods are inserted after the last command byte. During them the clock toggles and every `dq_oe` bit is 0. No gap is inserted otherwise.
- R7: `dq_oe` covers exactly the lanes in use for any byte that transmits: a command byte, or any single-lane byte. For a multi-lane byte with k>=C, `dq_oe` is 0.
- R8: While idle, `sclk` equals `cfg_sclk_idle_hi`. Inside a frame, each SCLK period is low for its first half and high for its second half.
- R9: `ready` is high exactly when no frame is in progress. A start strobe while `ready` is low has no effect on the running frame. A start strobe with a total of zero starts nothing.
- R10: Each transmitting byte is loaded from `tx_byte` with a `tx_take` pulse when `tx_avail` is high. Otherwise it is sent as 0x00 without a pulse. Receive-only bytes take nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Start strobe capturing the configuration |
| cfg_len_lo | input | LO_W | Low part of the frame byte count |
| cfg_len_hi | input | HI_W | Upper part of the frame byte count |
| cfg_cmd_len | input | CMD_W | Number of leading transmit-only bytes |
| cfg_idle | input | IDLE_W | Idle SCLK periods after the command phase |
| cfg_lane_mode | input | 2 | Phase-to-lane mapping |
| cfg_quad | input | 1 | Multi-lane width: 0 two lanes, 1 four lanes |
| cfg_div | input | DIV_W | Half-period length of SCLK in system clocks |
| cfg_sclk_idle_hi | input | 1 | Idle level of SCLK |
| tx_avail | input | 1 | A transmit byte is offered |
| tx_byte | input | 8 | Offered transmit byte |
| tx_take | output | 1 | The offered byte is consumed at this edge |
| rx_valid | output | 1 | One-cycle strobe for a returned byte |
| rx_byte | output | 8 | Returned byte |
| ready | output | 1 | Engine can accept a new frame |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| dq_o | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_i | input | 4 | Lane input values |

## Verification
Two events can land on the same system clock edge. The end of the last command byte can coincide with the entry into the idle gap, or with the load of the first data byte and its `tx_take`. The closing edge of the final byte can raise `rx_valid` in the same cycle that the tail period begins. Random frames with command counts of 0, 1, total-1 and total, idle counts of zero and non-zero, and divider values down to 1 provoke these coincidences. The bench judges them by rebuilding every lane beat from the edges recorded at rising SCLK, and by matching the chip-select low time and the number of returned bytes against counts it computes itself. A start strobe issued while the engine is busy checks that the frame still in flight is left untouched.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_TAIL} seq_st_e;

  // lanes used by one byte: 1, 2 or 4
  function automatic logic [2:0] lane_count(input logic [1:0] mode, input logic quad,
                                            input logic first, input logic in_cmd);
    logic [2:0] wide;
    wide = quad ? 3'd4 : 3'd2;
    case (mode)
      2'b00:   lane_count = 3'd1;
      2'b01:   lane_count = in_cmd ? 3'd1 : wide;
      2'b10:   lane_count = first ? 3'd1 : wide;
      default: lane_count = wide;
    endcase
  endfunction

  // index of the final beat of a byte
  function automatic logic [2:0] last_beat(input logic [2:0] lanes);
    case (lanes)
      3'd1:    last_beat = 3'd7;
      3'd2:    last_beat = 3'd3;
      default: last_beat = 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] lanes);
    case (lanes)
      3'd1:    lane_mask = 4'b0001;
      3'd2:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  input  logic       sample,
  input  logic [2:0] lanes,
  input  logic [3:0] dq_i,
  output logic [3:0] tx_bits,
  output logic [7:0] rx_word
);
  logic [7:0] sh_q;

  always_comb begin
    case (lanes)
      3'd1:    tx_bits = {3'b000, sh_q[7]};
      3'd2:    tx_bits = {2'b00, sh_q[7:6]};
      default: tx_bits = sh_q[7:4];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      rx_word <= '0;
    end else begin
      if (load) sh_q <= load_byte;
      else if (shift) begin
        case (lanes)
          3'd1:    sh_q <= {sh_q[6:0], 1'b0};
          3'd2:    sh_q <= {sh_q[5:0], 2'b00};
          default: sh_q <= {sh_q[3:0], 4'b0000};
        endcase
      end
      if (sample) begin
        case (lanes)
          3'd1:    rx_word <= {rx_word[6:0], dq_i[1]};
          3'd2:    rx_word <= {rx_word[5:0], dq_i[1:0]};
          default: rx_word <= {rx_word[3:0], dq_i};
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int LO_W   = 16,
  parameter int HI_W   = 16,
  parameter int CMD_W  = 9,
  parameter int IDLE_W = 4,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [LO_W-1:0]   cfg_len_lo,
  input  logic [HI_W-1:0]   cfg_len_hi,
  input  logic [CMD_W-1:0]  cfg_cmd_len,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic [1:0]        cfg_lane_mode,
  input  logic              cfg_quad,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_sclk_idle_hi,
  input  logic              tx_avail,
  input  logic [7:0]        tx_byte,
  output logic              tx_take,
  output logic              rx_valid,
  output logic [7:0]        rx_byte,
  output logic              ready,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_i
);
  localparam int CNT_W = LO_W + HI_W;
  localparam int CMP_W = (CNT_W > CMD_W) ? CNT_W : CMD_W;

  seq_st_e           state_q;
  logic [CNT_W-1:0]  total_q, byte_q;
  logic [CMP_W-1:0]  cmd_q;
  logic [IDLE_W-1:0] idle_q, gap_q;
  logic [1:0]        mode_q;
  logic              quad_q, pol_q, half_q, drive_q, rxphase_q, cs_n_q, rx_valid_q;
  logic [DIV_W-1:0]  div_q;
  logic [2:0]        beat_q, lanes_q;
  logic [7:0]        rx_byte_q;

  // named internal events
  logic [CNT_W-1:0]  total_in, next_idx, load_k;
  logic              start, tick, in_shift, last_byte, byte_end, enter_gap, gap_end, load_now;
  logic [1:0]        mode_use;
  logic              quad_use, ld_in_cmd, ld_drive;
  logic [CMP_W-1:0]  cmd_use;
  logic [2:0]        ld_lanes;
  logic [7:0]        ld_data, rx_word;
  logic [3:0]        tx_bits;

  assign total_in  = {cfg_len_hi, cfg_len_lo};
  assign start     = cfg_wr && (state_q == ST_IDLE) && (total_in != '0);
  assign in_shift  = (state_q == ST_SHIFT);
  assign next_idx  = byte_q + CNT_W'(1);
  assign last_byte = (next_idx == total_q);
  assign byte_end  = in_shift && tick && half_q && (beat_q == last_beat(lanes_q));
  assign enter_gap = byte_end && !last_byte && (CMP_W'(next_idx) == cmd_q) && (idle_q != '0);
  assign gap_end   = (state_q == ST_GAP) && tick && half_q && (gap_q == IDLE_W'(1));
  assign load_now  = start || (byte_end && !last_byte && !enter_gap) || gap_end;

  // lane decision for the byte being loaded
  assign load_k    = start ? '0 : ((state_q == ST_GAP) ? byte_q : next_idx);
  assign mode_use  = start ? cfg_lane_mode : mode_q;
  assign quad_use  = start ? cfg_quad : quad_q;
  assign cmd_use   = start ? CMP_W'(cfg_cmd_len) : cmd_q;
  assign ld_in_cmd = CMP_W'(load_k) < cmd_use;
  assign ld_lanes  = lane_count(mode_use, quad_use, load_k == '0, ld_in_cmd);
  assign ld_drive  = ld_in_cmd || (ld_lanes == 3'd1);
  assign tx_take   = load_now && ld_drive && tx_avail;
  assign ld_data   = tx_take ? tx_byte : 8'h00;

  spi_seq_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q != ST_IDLE),
    .div  (div_q),
    .tick (tick)
  );

  spi_seq_shifter u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_now),
    .load_byte(ld_data),
    .shift    (in_shift && tick && half_q),
    .sample   (in_shift && tick && !half_q),
    .lanes    (lanes_q),
    .dq_i     (dq_i),
    .tx_bits  (tx_bits),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      total_q    <= '0;
      cmd_q      <= '0;
      idle_q     <= '0;
      mode_q     <= '0;
      quad_q     <= 1'b0;
      pol_q      <= 1'b0;
      div_q      <= DIV_W'(1);
      byte_q     <= '0;
      beat_q     <= '0;
      half_q     <= 1'b0;
      gap_q      <= '0;
      cs_n_q     <= 1'b1;
      rx_valid_q <= 1'b0;
      rx_byte_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (start) begin
        total_q <= total_in;
        cmd_q   <= CMP_W'(cfg_cmd_len);
        idle_q  <= cfg_idle;
        mode_q  <= cfg_lane_mode;
        quad_q  <= cfg_quad;
        pol_q   <= cfg_sclk_idle_hi;
        div_q   <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
        byte_q  <= '0;
        beat_q  <= '0;
        half_q  <= 1'b0;
        cs_n_q  <= 1'b0;
        state_q <= ST_SHIFT;
      end else if (tick) begin
        half_q <= ~half_q;
        case (state_q)
          ST_SHIFT: if (half_q) begin
            if (byte_end) begin
              beat_q     <= '0;
              byte_q     <= next_idx;
              rx_valid_q <= rxphase_q;
              rx_byte_q  <= rx_word;
              if (last_byte) state_q <= ST_TAIL;
              else if (enter_gap) begin
                state_q <= ST_GAP;
                gap_q   <= idle_q;
              end
            end else begin
              beat_q <= beat_q + 3'd1;
            end
          end
          ST_GAP: if (half_q) begin
            gap_q <= gap_q - IDLE_W'(1);
            if (gap_q == IDLE_W'(1)) state_q <= ST_SHIFT;
          end
          ST_TAIL: if (half_q) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q   <= 3'd1;
      drive_q   <= 1'b0;
      rxphase_q <= 1'b0;
    end else if (load_now) begin
      lanes_q   <= ld_lanes;
      drive_q   <= ld_drive;
      rxphase_q <= !ld_in_cmd;
    end
  end

  always_comb begin
    case (state_q)
      ST_IDLE: sclk = cfg_sclk_idle_hi;
      ST_TAIL: sclk = pol_q;
      default: sclk = half_q;
    endcase
  end

  assign dq_oe    = (in_shift && drive_q) ? lane_mask(lanes_q) : 4'b0000;
  assign dq_o     = in_shift ? tx_bits : 4'b0000;
  assign ready    = (state_q == ST_IDLE);
  assign cs_n     = cs_n_q;
  assign rx_valid = rx_valid_q;
  assign rx_byte  = rx_byte_q;
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             cs_n,
  input logic             sclk,
  input logic             cfg_sclk_idle_hi,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] total_q,
  input logic             rx_valid,
  input logic             tx_take,
  input logic             tx_avail,
  input logic [3:0]       dq_oe,
  input logic [2:0]       lanes_q,
  input logic             rxphase_q,
  input logic             in_shift
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sclk == cfg_sclk_idle_hi)); // R8
  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shift && rxphase_q && lanes_q != 3'd1) |-> (dq_oe == 4'b0000)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !ready) |=> $stable(total_q)); // R9
  AST_RX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n); // R3
  AST_TAKE_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_avail); // R10
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shift && lanes_q == 3'd1) |-> (dq_oe[3:1] == 3'b000)); // R5
endmodule

bind spi_frame_seq spi_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ready           (ready),
  .cs_n            (cs_n),
  .sclk            (sclk),
  .cfg_sclk_idle_hi(cfg_sclk_idle_hi),
  .cfg_wr          (cfg_wr),
  .total_q         (total_q),
  .rx_valid        (rx_valid),
  .tx_take         (tx_take),
  .tx_avail        (tx_avail),
  .dq_oe           (dq_oe),
  .lanes_q         (lanes_q),
  .rxphase_q       (rxphase_q),
  .in_shift        (in_shift)
);

// File: tb/tb_spi_frame_seq.sv
module tb_spi_frame_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_len_lo = '0;
  logic [1:0] cfg_len_hi = '0;
  logic [8:0] cfg_cmd_len = '0;
  logic [3:0] cfg_idle = '0;
  logic [1:0] cfg_lane_mode = '0;
  logic       cfg_quad = 1'b0;
  logic [3:0] cfg_div = 4'd1;
  logic       cfg_sclk_idle_hi = 1'b0;
  logic       tx_avail = 1'b1;
  logic [7:0] tx_byte;
  logic       tx_take, rx_valid, ready, sclk, cs_n;
  logic [7:0] rx_byte;
  logic [3:0] dq_o, dq_oe, dq_i;

  int nchk = 0, nfail = 0;
  int rc = 0, cs_cnt = 0, rxn = 0, tx_idx = 0, takes = 0;
  logic [3:0] nib [512];
  logic [3:0] rec_o [512];
  logic [3:0] rec_oe [512];
  logic [7:0] txq [64];
  logic [7:0] rxcap [64];

  always #10 clk = ~clk; // 50 MHz

  spi_frame_seq #(.LO_W(3), .HI_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_len_lo(cfg_len_lo),
    .cfg_len_hi(cfg_len_hi), .cfg_cmd_len(cfg_cmd_len), .cfg_idle(cfg_idle),
    .cfg_lane_mode(cfg_lane_mode), .cfg_quad(cfg_quad), .cfg_div(cfg_div),
    .cfg_sclk_idle_hi(cfg_sclk_idle_hi), .tx_avail(tx_avail), .tx_byte(tx_byte),
    .tx_take(tx_take), .rx_valid(rx_valid), .rx_byte(rx_byte), .ready(ready),
    .sclk(sclk), .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  assign dq_i    = nib[rc % 512];
  assign tx_byte = txq[tx_idx % 64];

  // flash-side model: record lanes and move to next nibble at rising SCLK
  always @(posedge sclk) begin
    if (cs_n === 1'b0) begin
      rec_o[rc % 512]  = dq_o;
      rec_oe[rc % 512] = dq_oe;
      rc = rc + 1;
    end
  end

  always @(posedge clk) begin
    if (tx_take === 1'b1) begin
      tx_idx <= tx_idx + 1;
      takes  <= takes + 1;
    end
  end

  always @(negedge clk) begin
    if (cs_n === 1'b0) cs_cnt = cs_cnt + 1;
    if (rx_valid === 1'b1) begin
      rxcap[rxn % 64] = rx_byte;
      rxn = rxn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int blanes(int mode, int quad, int k, int cmd);
    int m;
    m = quad ? 4 : 2;
    if (mode == 0) return 1;
    if (mode == 3) return m;
    if (mode == 2) return (k == 0) ? 1 : m;
    return (k < cmd) ? 1 : m;
  endfunction

  task automatic run_frame(int lo, int hi, int cmd, int idle, int mode, int quad,
                           int div, int pol, int avail, int poke);
    int total, n, r, rc0, cs0, rx0, tk0, tb0, j, m, bad_oe, L, msk, txv, rv, expb;
    total = hi * 8 + lo;
    n = (div == 0) ? 1 : div;
    for (int i = 0; i < 200; i++) nib[(rc + i) % 512] = 4'($urandom % 16);
    for (int i = 0; i < 32; i++) txq[(tx_idx + i) % 64] = 8'($urandom % 256);
    @(negedge clk);
    rc0 = rc; cs0 = cs_cnt; rx0 = rxn; tk0 = takes; tb0 = tx_idx;
    cfg_len_lo = 3'(lo); cfg_len_hi = 2'(hi); cfg_cmd_len = 9'(cmd);
    cfg_idle = 4'(idle); cfg_lane_mode = 2'(mode); cfg_quad = quad[0];
    cfg_div = 4'(div); cfg_sclk_idle_hi = pol[0]; tx_avail = avail[0];
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (total == 0) begin
      repeat (4) @(negedge clk);
      chk(ready === 1'b1, "R9 zero-length start ready", int'(ready), 1);
      chk(cs_n === 1'b1, "R9 zero-length start cs_n", int'(cs_n), 1);
      return;
    end
    chk(ready === 1'b0, "R9 busy after start", int'(ready), 0);
    if (poke) begin
      @(negedge clk);
      cfg_len_lo = ~cfg_len_lo; cfg_lane_mode = ~cfg_lane_mode; cfg_div = 4'd7;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
    end
    while (ready !== 1'b1) @(negedge clk);
    // rebuild frame from recorded beats
    r = rc0; j = 0; m = 0; bad_oe = 0;
    for (int k = 0; k < total; k++) begin
      bit txing;
      L = blanes(mode, quad, k, cmd);
      msk = (1 << L) - 1;
      txing = (k < cmd) || (L == 1);
      txv = 0; rv = 0;
      for (int b = 0; b < 8 / L; b++) begin
        if (int'(rec_oe[r % 512]) != (txing ? msk : 0)) bad_oe++;
        txv = (txv << L) | (int'(rec_o[r % 512]) & msk);
        rv  = (rv << L) | ((L == 1) ? ((int'(nib[r % 512]) >> 1) & 1) : (int'(nib[r % 512]) & msk));
        r++;
      end
      if (txing) begin
        expb = avail ? int'(txq[(tb0 + j) % 64]) : 0;
        j++;
        chk((txv & 255) == expb, "R5 R10 transmitted byte", txv & 255, expb);
      end
      if (k >= cmd) begin
        chk(int'(rxcap[(rx0 + m) % 64]) == (rv & 255), "R4 returned byte",
            int'(rxcap[(rx0 + m) % 64]), rv & 255);
        m++;
      end
      if (k + 1 == cmd && cmd < total) begin
        for (int g = 0; g < idle; g++) begin
          chk(rec_oe[r % 512] == 4'b0000, "R6 lanes released in gap", int'(rec_oe[r % 512]), 0);
          r++;
        end
      end
    end
    chk(bad_oe == 0, "R7 output enables per beat", bad_oe, 0);
    chk(rc - rc0 == r - rc0, "R6 SCLK rising edges in frame", rc - rc0, r - rc0);
    chk(rxn - rx0 == m, "R3 returned byte count", rxn - rx0, m);
    chk(takes - tk0 == (avail ? j : 0), "R10 source bytes taken", takes - tk0, avail ? j : 0);
    chk(cs_cnt - cs0 == 2 * n * (r - rc0 + 1), "R1 R2 chip select low time",
        cs_cnt - cs0, 2 * n * (r - rc0 + 1));
    chk(sclk === pol[0], "R8 idle level after frame", int'(sclk), pol);
    cfg_len_lo = '0; cfg_len_hi = '0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) nib[i] = 4'd0;
    for (int i = 0; i < 64; i++) begin txq[i] = 8'd0; rxcap[i] = 8'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R9 reset ready", int'(ready), 1);
    chk(cs_n === 1'b1, "R1 reset cs_n", int'(cs_n), 1);
    chk(dq_oe === 4'b0000, "R7 reset output enables", int'(dq_oe), 0);
    chk(sclk === 1'b0, "R8 reset idle level", int'(sclk), 0);
    chk(rx_valid === 1'b0, "R3 reset rx_valid", int'(rx_valid), 0);
    // directed corners
    run_frame(3, 0, 3, 0, 0, 0, 1, 0, 1, 0); // R3 cmd equals total, nothing returned
    run_frame(4, 0, 0, 0, 0, 0, 2, 0, 1, 0); // R3 cmd zero, all returned
    run_frame(6, 0, 4, 2, 1, 1, 1, 0, 1, 0); // R5 R6 quad read after single-lane address
    run_frame(5, 0, 3, 1, 2, 0, 3, 1, 1, 0); // R5 dual address, single opcode, idle high
    run_frame(5, 0, 2, 3, 3, 1, 1, 0, 1, 0); // R5 all lanes quad
    run_frame(0, 0, 0, 0, 0, 0, 1, 0, 1, 0); // R9 zero length
    run_frame(4, 0, 1, 2, 1, 0, 2, 0, 1, 1); // R9 start while busy
    run_frame(2, 1, 4, 1, 0, 0, 1, 0, 1, 0); // R1 upper count field
    run_frame(3, 0, 1, 0, 0, 0, 0, 0, 1, 0); // R2 divider zero acts as one
    run_frame(4, 0, 4, 0, 3, 1, 1, 1, 0, 0); // R10 empty source sends zeros
    run_frame(3, 0, 5, 1, 0, 0, 1, 0, 1, 0); // R3 cmd above total
    for (int it = 0; it < 30; it++) begin
      int lo, hi, tot;
      lo = $urandom % 8;
      hi = ($urandom % 4 == 0) ? 1 : 0;
      tot = hi * 8 + lo;
      if (tot == 0) begin lo = 1; tot = 1; end
      run_frame(lo, hi, $urandom % (tot + 1), $urandom % 4, $urandom % 4, $urandom % 2,
                $urandom % 4, $urandom % 2, ($urandom % 4) != 0, ($urandom % 4) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule